// File: doc/BRIEF.md
# Set/Clear Interrupt Aggregator

This block gathers 24 interrupt sources into one upstream interrupt line. It also gives the handler an encoded vector that names the source to service. Each source is captured in one of two ways, and a fixed parameter mask picks the way for each source. A level source is re-sampled on every cycle, so it tracks its input. An edge source latches a rising edge and holds it until software acknowledges it.

Software never writes the enable state directly. A set strobe turns enable bits on, and a clear strobe turns them off. A pending edge bit is acknowledged by writing 1 to it. The effective request is the pending state masked by the enables, and the lowest-numbered effective source is reported first.

A secondary Ethernet status/enable pair feeds a reserved fallback slot, source 23. That slot is reported only when no source in the main set is effectively pending.

Top module: `irq_concentrator`

## Requirements
- R1: After reset, `pending_o` and `enable_o` are all zero, `irq_o` and `vec_valid_o` are low, and `vec_idx_o` is 0.
- R2: Each 1 in `en_set_i` sets that bit of `enable_o`, and each 1 in `en_clr_i` clears it, one clock later. If both strobes hit the same bit in one cycle, the clear wins.
- R3: For an edge source, a 1 in `ack_i` clears that bit of `pending_o` one clock later, provided no new rising edge arrives in the same cycle.
- R4: An edge source sets its `pending_o` bit one clock after a 0-to-1 transition of its input. The bit stays set after the input falls. If a rising edge and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R5: Sources 0, 2, 6, 9, 11 and 15 are level sources. Their `pending_o` bit equals the input as sampled one clock earlier, and `ack_i` has no effect on them.
- R6: When `pending_o & enable_o` is non-zero, `vec_valid_o` is 1 and `vec_idx_o` is the index of its lowest set bit.
- R7: When `pending_o & enable_o` is zero and `eth_status_i & eth_enable_i` is non-zero, `vec_valid_o` is 1 and `vec_idx_o` is 23. This path is combinational from the Ethernet inputs.
- R8: `irq_o` equals `vec_valid_o` at all times. When no vector is valid, `vec_idx_o` is 0.
- R9: A pending bit whose enable is clear stays visible on `pending_o` but does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 24 | Raw interrupt source inputs |
| ack_i | input | 24 | Write-1-to-acknowledge strobe for pending bits |
| en_set_i | input | 24 | Write-1-to-set enable strobe |
| en_clr_i | input | 24 | Write-1-to-clear enable strobe |
| eth_status_i | input | 32 | Ethernet status word |
| eth_enable_i | input | 32 | Ethernet enable word |
| pending_o | output | 24 | Raw pending state |
| enable_o | output | 24 | Enable state |
| irq_o | output | 1 | Upstream interrupt |
| vec_idx_o | output | 5 | Encoded index of the source to service |
| vec_valid_o | output | 1 | Vector index is meaningful |

## Verification
A source change, a strobe or an acknowledge is latched on the first rising edge after it is driven, so `pending_o` and `enable_o` change in that same cycle. Because the encoder is combinational over those registers, the vector follows in the same cycle. The Ethernet fallback has no register on its path, so it shows without any clock edge. The bench drives every input on the falling edge. It samples one nanosecond after the next rising edge for registered results, and one nanosecond after the drive for the Ethernet path. No check depends on the order of processes at an edge.

// File: rtl/irq_conc_pkg.sv
package irq_conc_pkg;
    // Sources 0, 2, 6, 9, 11 and 15 follow their input; the rest latch edges.
    localparam logic [23:0] DEF_LEVEL_MASK = 24'h008A45;
    localparam int          DEF_NUM_SRC    = 24;
    localparam int          DEF_AUX_W      = 32;
    localparam int          DEF_FALLBACK   = 23;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_MAIN = 2'd1,
        PICK_AUX  = 2'd2
    } pick_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int                 NUM_SRC    = 24,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] pend;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_SRC-1:0] pend_nxt;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            if (LEVEL_MASK[i]) begin : g_level
                assign pend_nxt[i] = src_i[i];
            end else begin : g_edge
                logic rise;
                assign rise        = src_i[i] & ~cap_q.prev[i];
                assign pend_nxt[i] = rise | (cap_q.pend[i] & ~ack_i[i]);
            end
        end
    endgenerate

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = src_i;
        cap_d.pend = pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pend_o = cap_q.pend;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_d, en_q;

    // Clear is applied last so it wins over a simultaneous set.
    always_comb begin
        en_d = (en_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_conc_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int FALLBACK = 23,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] eff_i,
    input  logic               aux_hit_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    pick_e              sel;
    logic [IDX_W-1:0]   low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eff_i[i]) low_idx = IDX_W'(i);
        end
        if (|eff_i)         sel = PICK_MAIN;
        else if (aux_hit_i) sel = PICK_AUX;
        else                sel = PICK_NONE;
    end

    always_comb begin
        unique case (sel)
            PICK_MAIN: begin valid_o = 1'b1; idx_o = low_idx;           end
            PICK_AUX:  begin valid_o = 1'b1; idx_o = IDX_W'(FALLBACK);  end
            default:   begin valid_o = 1'b0; idx_o = '0;                end
        endcase
    end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irq_conc_pkg::*;
#(
    parameter int                 NUM_SRC    = DEF_NUM_SRC,
    parameter int                 AUX_W      = DEF_AUX_W,
    parameter int                 FALLBACK   = DEF_FALLBACK,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = DEF_LEVEL_MASK,
    localparam int                IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic [NUM_SRC-1:0] en_set_i,
    input  logic [NUM_SRC-1:0] en_clr_i,
    input  logic [AUX_W-1:0]   eth_status_i,
    input  logic [AUX_W-1:0]   eth_enable_i,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] enable_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   vec_idx_o,
    output logic               vec_valid_o
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] eff;
    logic               aux_hit;

    irq_capture #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .ack_i  (ack_i),
        .pend_o (pend)
    );

    irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set_i),
        .clr_i (en_clr_i),
        .en_o  (en)
    );

    assign eff     = pend & en;
    assign aux_hit = |(eth_status_i & eth_enable_i);

    irq_pick #(.NUM_SRC(NUM_SRC), .FALLBACK(FALLBACK)) u_pick (
        .eff_i     (eff),
        .aux_hit_i (aux_hit),
        .valid_o   (vec_valid_o),
        .idx_o     (vec_idx_o)
    );

    assign pending_o = pend;
    assign enable_o  = en;
    assign irq_o     = vec_valid_o;
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk #(
    parameter int                 NUM_SRC    = 24,
    parameter int                 AUX_W      = 32,
    parameter int                 FALLBACK   = 23,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    localparam int                IDX_W      = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] ack_i,
    input logic [NUM_SRC-1:0] en_set_i,
    input logic [NUM_SRC-1:0] en_clr_i,
    input logic [AUX_W-1:0]   eth_status_i,
    input logic [AUX_W-1:0]   eth_enable_i,
    input logic [NUM_SRC-1:0] pending_o,
    input logic [NUM_SRC-1:0] enable_o,
    input logic               irq_o,
    input logic [IDX_W-1:0]   vec_idx_o,
    input logic               vec_valid_o
);
    localparam logic [NUM_SRC-1:0] EDGE = ~LEVEL_MASK;

    logic [NUM_SRC-1:0] src_seen_q, ackd_q, rose_q, set_q, clr_q;
    logic [NUM_SRC-1:0] rise, eff;

    assign rise = src_i & ~src_seen_q;
    assign eff  = pending_o & enable_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_seen_q <= '0;
            ackd_q     <= '0;
            rose_q     <= '0;
            set_q      <= '0;
            clr_q      <= '0;
        end else begin
            src_seen_q <= src_i;
            ackd_q     <= ack_i & ~rise & EDGE;
            rose_q     <= rise & EDGE;
            set_q      <= en_set_i & ~en_clr_i;
            clr_q      <= en_clr_i;
        end
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (pending_o == '0 && enable_o == '0 && !irq_o));

    // R2
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o & set_q) == set_q);

    // R2
    enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o & clr_q) == '0);

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & ackd_q) == '0);

    // R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & rose_q) == rose_q);

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & LEVEL_MASK) == (src_seen_q & LEVEL_MASK));

    // R6
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff != '0) |-> (vec_valid_o && eff[vec_idx_o] &&
                         (eff & ((NUM_SRC'(1) << vec_idx_o) - NUM_SRC'(1))) == '0));

    // R7
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == '0 && (eth_status_i & eth_enable_i) != '0) |->
            (vec_valid_o && vec_idx_o == IDX_W'(FALLBACK)));

    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o == vec_valid_o) && (vec_valid_o || vec_idx_o == '0));
endmodule

bind irq_concentrator irq_concentrator_chk #(
    .NUM_SRC(NUM_SRC), .AUX_W(AUX_W), .FALLBACK(FALLBACK), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ack_i(ack_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .eth_status_i(eth_status_i), .eth_enable_i(eth_enable_i),
    .pending_o(pending_o), .enable_o(enable_o), .irq_o(irq_o),
    .vec_idx_o(vec_idx_o), .vec_valid_o(vec_valid_o)
);

// File: tb/irq_concentrator_bench.sv
module irq_concentrator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src = '0, ack = '0, eset = '0, eclr = '0;
    logic [31:0] eth_st = '0, eth_en = '0;
    logic [23:0] pending, enable;
    logic        irq, vvalid;
    logic [4:0]  vidx;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_concentrator u_irq_concentrator (
        .clk(clk), .rst_n(rst_n), .src_i(src), .ack_i(ack),
        .en_set_i(eset), .en_clr_i(eclr),
        .eth_status_i(eth_st), .eth_enable_i(eth_en),
        .pending_o(pending), .enable_o(enable), .irq_o(irq),
        .vec_idx_o(vidx), .vec_valid_o(vvalid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply stimulus on the falling edge, let one rising edge latch it, sample 1 ns later.
    task automatic step();
        @(posedge clk);
        #1;
        ack  = '0;
        eset = '0;
        eclr = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pending", pending, 0);
        chk("R1 enable", enable, 0);
        chk("R1 irq", irq, 0);
        chk("R1 idx", vidx, 0);
    endtask

    task automatic t_enable();
        @(negedge clk); eset = 24'hFFFFFF; step();
        chk("R2 set all", enable, 24'hFFFFFF);
        @(negedge clk); eset = 24'h000008; eclr = 24'h000008; step();
        chk("R2 clear wins", enable, 24'hFFFFF7);
    endtask

    task automatic t_edge();
        @(negedge clk); src[5] = 1'b1; step();
        chk("R4 edge latched", pending, 24'h000020);
        chk("R6 idx 5", vidx, 5);
        @(negedge clk); src[5] = 1'b0; step();
        chk("R4 held after fall", pending, 24'h000020);
        @(negedge clk); ack = 24'h000020; step();
        chk("R3 ack clears", pending, 0);
        chk("R8 irq low", irq, 0);
        chk("R8 idx zero", vidx, 0);
        @(negedge clk); src[7] = 1'b1; ack = 24'h000080; step();
        chk("R4 event beats ack", pending, 24'h000080);
        @(negedge clk); ack = 24'h000080; step();
        chk("R3 ack with input high", pending, 0);
        @(negedge clk); src[7] = 1'b0; step();
    endtask

    task automatic t_level();
        @(negedge clk); src[2] = 1'b1; step();
        chk("R5 level tracks", pending, 24'h000004);
        chk("R6 idx 2", vidx, 2);
        @(negedge clk); ack = 24'h000004; step();
        chk("R5 ack ignored", pending, 24'h000004);
        @(negedge clk); src[2] = 1'b0; step();
        chk("R5 level drops", pending, 0);
    endtask

    task automatic t_priority();
        @(negedge clk); src[9] = 1'b1; src[12] = 1'b1; step();
        chk("R6 both pending", pending, 24'h001200);
        chk("R6 lowest wins", vidx, 9);
        @(negedge clk); eclr = 24'h000200; step();
        chk("R6 masked falls through", vidx, 12);
        chk("R9 masked still pending", pending, 24'h001200);
        @(negedge clk); eclr = 24'h001000; step();
        chk("R9 no irq when masked", irq, 0);
        @(negedge clk); eset = 24'h001200; src[9] = 1'b0; src[12] = 1'b0; ack = 24'h001000; step();
        chk("R3 cleanup", pending, 0);
    endtask

    task automatic t_fallback();
        @(negedge clk); eth_st = 32'h10; eth_en = 32'h10; #1;
        chk("R7 fallback valid", vvalid, 1);
        chk("R7 fallback idx", vidx, 23);
        @(negedge clk); src[4] = 1'b1; step();
        chk("R7 main beats fallback", vidx, 4);
        @(negedge clk); ack = 24'h000010; src[4] = 1'b0; eth_en = 32'h0; step();
        chk("R8 irq idle", irq, 0);
        chk("R7 disabled aux", vvalid, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_enable();
        t_edge();
        t_level();
        t_priority();
        t_fallback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule